// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status Register

This block is the arithmetic and logic stage of an 8-bit accumulator-style core. It takes the working-register value and a file operand, both already fetched, and returns an 8-bit result in the same cycle. The operation is selected by a 4-bit code. The results of the current operation also drive a five-bit status register. When `op_valid` is high, that register is written on the next rising clock edge, but only for the flags the selected operation affects. Fetching operands, decoding instructions and writing results back all sit outside this block.

There is one shared adder for every arithmetic operation. Subtraction is done by adding the inverted working value with a carry-in of one. As a result, the carry and digit-carry flags read 1 when no borrow occurs. Add-with-carry takes its carry-in from the stored carry flag, so multi-byte sums can be built from a chain of byte operations.

The status layout is fixed because downstream logic decodes it:
- bit 0: carry (C)
- bit 1: digit carry (DC)
- bit 2: zero (Z)
- bit 3: overflow (OV)
- bit 4: negative (N)

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives result = f + w modulo 256. C is the carry out of bit 7. For example, f=0x9F and w=0x52 give 0xF1 with status 0x12 (N=1, DC=1, others 0).
- R2: Op code 1 (add with carry) gives result = f + w + C, where C is the stored status bit 0 at the time of the operation. It updates all five flags as an add does.
- R3: Op code 2 (subtract) gives result = f − w modulo 256, that is, the file operand minus the working value. C (bit 0) is 1 when f ≥ w unsigned and 0 when a borrow occurs.
- R4: DC (bit 1) is the carry out of the low nibble in the shared adder. For subtraction this means DC=1 when the low nibble of f is greater than or equal to the low nibble of w.
- R5: OV (bit 3) is set when the signed two's-complement result of an arithmetic operation does not fit in 8 bits.
- R6: Z (bit 2) is set after any flag-updating operation whose 8-bit result is 0x00, and cleared otherwise.
- R7: N (bit 4) equals bit 7 of the result after every flag-updating operation, arithmetic or logic.
- R8: Op code 4 (increment) gives f + 1 and op code 5 (decrement) gives f − 1. Both update all five flags, and decrement follows the borrow convention for C and DC.
- R9: Op codes 3 (move f), 6 (AND), 7 (OR) and 8 (XOR) give the expected result, update only Z and N, and leave C, DC and OV unchanged.
- R10: The status register changes only on a clock edge where `op_valid` is high. Op codes 9 to 15 are reserved: they pass f to the result and change no flag.
- R11: After reset the status register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | High when the presented operation should commit its flags |
| op_code | input | 4 | Operation selector (0 add, 1 add with carry, 2 subtract, 3 move, 4 increment, 5 decrement, 6 AND, 7 OR, 8 XOR) |
| w_in | input | 8 | Working-register operand |
| f_in | input | 8 | File operand |
| result | output | 8 | Combinational result of the selected operation |
| status | output | 5 | Registered flags {N, OV, Z, DC, C} |

## Verification
Several behaviours are checked by the assertions on every cycle:
- Z and N track the result of the previous committed operation.
- Subtract carry follows the unsigned f ≥ w comparison.
- The add result equals the modular sum.
- Logic and move operations hold C, DC and OV.
- No flag moves without `op_valid`.

Other behaviours need scenarios that only the bench can set up: the exact digit-carry and overflow patterns at the sign and nibble boundaries, the stored carry feeding add-with-carry, the borrow cases of increment and decrement, the reserved codes, and the reset value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int NFLG   = 5;
    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;
    localparam int FLG_N  = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_MOV  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_AND  = 4'd6,
        OP_IOR  = 4'd7,
        OP_XOR  = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_NONE
    } op_class_e;

    typedef enum logic [1:0] {
        BSEL_W,
        BSEL_WINV,
        BSEL_ZERO,
        BSEL_ONES
    } bsel_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG
    } cinsel_e;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [3:0] op_code,
    output op_class_e  op_class,
    output bsel_e      b_sel,
    output cinsel_e    cin_sel
);

    always_comb begin
        op_class = CLS_NONE;
        b_sel    = BSEL_W;
        cin_sel  = CIN_ZERO;
        unique case (op_code)
            OP_ADD:  begin op_class = CLS_ARITH; b_sel = BSEL_W;    cin_sel = CIN_ZERO; end
            OP_ADDC: begin op_class = CLS_ARITH; b_sel = BSEL_W;    cin_sel = CIN_FLAG; end
            OP_SUB:  begin op_class = CLS_ARITH; b_sel = BSEL_WINV; cin_sel = CIN_ONE;  end
            OP_INC:  begin op_class = CLS_ARITH; b_sel = BSEL_ZERO; cin_sel = CIN_ONE;  end
            OP_DEC:  begin op_class = CLS_ARITH; b_sel = BSEL_ONES; cin_sel = CIN_ZERO; end
            OP_MOV, OP_AND, OP_IOR, OP_XOR: begin
                op_class = CLS_LOGIC;
            end
            default: op_class = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hcout,
    output logic          ovf
);

    localparam int HW = DW / 2;

    logic [HW:0] low_sum;
    logic [DW:0] full_sum;

    always_comb begin
        low_sum  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
        full_sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        sum      = full_sum[DW-1:0];
        cout     = full_sum[DW];
        hcout    = low_sum[HW];
        ovf      = (a[DW-1] == b[DW-1]) && (full_sum[DW-1] != a[DW-1]);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] w_val,
    input  logic [DW-1:0] f_val,
    output logic [DW-1:0] res
);

    always_comb begin
        unique case (op_code)
            OP_AND:  res = f_val & w_val;
            OP_IOR:  res = f_val | w_val;
            OP_XOR:  res = f_val ^ w_val;
            default: res = f_val;
        endcase
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_all,
    input  logic            upd_zn,
    input  logic [DW-1:0]   res,
    input  logic            c_new,
    input  logic            dc_new,
    input  logic            ov_new,
    output logic [NFLG-1:0] flags
);

    logic [NFLG-1:0] flags_nxt;

    always_comb begin
        flags_nxt = flags;
        if (upd_all || upd_zn) begin
            flags_nxt[FLG_Z] = (res == '0);
            flags_nxt[FLG_N] = res[DW-1];
        end
        if (upd_all) begin
            flags_nxt[FLG_C]  = c_new;
            flags_nxt[FLG_DC] = dc_new;
            flags_nxt[FLG_OV] = ov_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [DW-1:0]   w_in,
    input  logic [DW-1:0]   f_in,
    output logic [DW-1:0]   result,
    output logic [NFLG-1:0] status
);

    op_class_e     op_class;
    bsel_e         b_sel;
    cinsel_e       cin_sel;
    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [DW-1:0] add_sum;
    logic          add_c;
    logic          add_dc;
    logic          add_ov;
    logic [DW-1:0] log_res;

    alu8_decode u_dec (
        .op_code  (op_code),
        .op_class (op_class),
        .b_sel    (b_sel),
        .cin_sel  (cin_sel)
    );

    always_comb begin
        unique case (b_sel)
            BSEL_W:    add_b = w_in;
            BSEL_WINV: add_b = ~w_in;
            BSEL_ZERO: add_b = '0;
            default:   add_b = '1;
        endcase
        unique case (cin_sel)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = status[FLG_C];
            default:  add_cin = 1'b0;
        endcase
    end

    alu8_adder #(.DW(DW)) u_add (
        .a     (f_in),
        .b     (add_b),
        .cin   (add_cin),
        .sum   (add_sum),
        .cout  (add_c),
        .hcout (add_dc),
        .ovf   (add_ov)
    );

    alu8_logic #(.DW(DW)) u_log (
        .op_code (op_code),
        .w_val   (w_in),
        .f_val   (f_in),
        .res     (log_res)
    );

    assign result = (op_class == CLS_ARITH) ? add_sum : log_res;

    alu8_status #(.DW(DW)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_all (op_valid && (op_class == CLS_ARITH)),
        .upd_zn  (op_valid && (op_class == CLS_LOGIC)),
        .res     (result),
        .c_new   (add_c),
        .dc_new  (add_dc),
        .ov_new  (add_ov),
        .flags   (status)
    );

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [3:0]      op_code,
    input logic [DW-1:0]   w_in,
    input logic [DW-1:0]   f_in,
    input logic [DW-1:0]   result,
    input logic [NFLG-1:0] status
);

    logic flag_op;
    logic logic_op;
    assign flag_op  = (op_code <= 4'd8);
    assign logic_op = (op_code == OP_MOV) || (op_code == OP_AND) ||
                      (op_code == OP_IOR) || (op_code == OP_XOR);

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_ADD) |-> (result == DW'(f_in + w_in)));

    // R3
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SUB) |=> (status[FLG_C] == ($past(f_in) >= $past(w_in))));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_op) |=> (status[FLG_Z] == ($past(result) == '0)));

    // R7
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_op) |=> (status[FLG_N] == $past(result[DW-1])));

    // R9
    logic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && logic_op) |=> ($stable(status[FLG_C]) && $stable(status[FLG_DC]) &&
                                    $stable(status[FLG_OV])));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || !flag_op) |=> $stable(status));

endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .w_in     (w_in),
    .f_in     (f_in),
    .result   (result),
    .status   (status)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] w_in = 8'h00;
    logic [7:0] f_in = 8'h00;
    logic [7:0] result;
    logic [4:0] status;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    alu8_core i_alu8_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .w_in     (w_in),
        .f_in     (f_in),
        .result   (result),
        .status   (status)
    );

    // {op, w, f, expected result, expected status, status mask, requirement number}
    localparam int NV = 20;
    localparam logic [41:0] VEC [0:NV-1] = '{
        {4'd0, 8'h52, 8'h9F, 8'hF1, 5'h12, 5'h1F, 4'd1},  // R1 worked example
        {4'd0, 8'h01, 8'hFF, 8'h00, 5'h07, 5'h1F, 4'd6},  // R6 wrap to zero
        {4'd0, 8'h01, 8'h7F, 8'h80, 5'h1A, 5'h1F, 4'd5},  // R5 positive overflow
        {4'd0, 8'h80, 8'h80, 8'h00, 5'h0D, 5'h1F, 4'd5},  // R5 negative overflow
        {4'd2, 8'h03, 8'h05, 8'h02, 5'h03, 5'h1F, 4'd3},  // R3 no borrow
        {4'd2, 8'h05, 8'h03, 8'hFE, 5'h10, 5'h1F, 4'd3},  // R3 borrow
        {4'd2, 8'h42, 8'h42, 8'h00, 5'h07, 5'h1F, 4'd6},  // R6 equal operands
        {4'd2, 8'h01, 8'h80, 8'h7F, 5'h09, 5'h1F, 4'd5},  // R5 subtract overflow
        {4'd2, 8'h01, 8'h10, 8'h0F, 5'h01, 5'h1F, 4'd4},  // R4 nibble borrow
        {4'd4, 8'h00, 8'hFF, 8'h00, 5'h07, 5'h1F, 4'd8},  // R8 increment wrap
        {4'd4, 8'h00, 8'h7F, 8'h80, 5'h1A, 5'h1F, 4'd8},  // R8 increment overflow
        {4'd5, 8'h00, 8'h00, 8'hFF, 5'h10, 5'h1F, 4'd8},  // R8 decrement borrow
        {4'd5, 8'h00, 8'h80, 8'h7F, 5'h09, 5'h1F, 4'd8},  // R8 decrement overflow
        {4'd5, 8'h00, 8'h01, 8'h00, 5'h07, 5'h1F, 4'd8},  // R8 decrement to zero
        {4'd6, 8'hF0, 8'h0F, 8'h00, 5'h04, 5'h14, 4'd9},  // R9 AND
        {4'd7, 8'h80, 8'h01, 8'h81, 5'h10, 5'h14, 4'd9},  // R9 OR
        {4'd8, 8'hAA, 8'hAA, 8'h00, 5'h04, 5'h14, 4'd9},  // R9 XOR zero
        {4'd3, 8'h12, 8'h00, 8'h00, 5'h04, 5'h14, 4'd9},  // R9 move zero
        {4'd3, 8'h12, 8'hC3, 8'hC3, 5'h10, 5'h14, 4'd7},  // R7 move negative
        {4'd8, 8'h0F, 8'hF0, 8'hFF, 5'h10, 5'h14, 4'd7}   // R7 XOR negative
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] w, input logic [7:0] f,
                         input logic vld, output logic [7:0] r);
        @(negedge clk);
        op_code  = op;
        w_in     = w;
        f_in     = f;
        op_valid = vld;
        #1 r = result;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [4:0] s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({3'b0, status}, 8'h00, "R11", "status after reset");

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            apply(v[41:38], v[37:30], v[29:22], 1'b1, r);
            check(r, v[21:14], $sformatf("R%0d", v[3:0]), $sformatf("vector %0d result", i));
            check({3'b0, status & v[8:4]}, {3'b0, v[13:9] & v[8:4]},
                  $sformatf("R%0d", v[3:0]), $sformatf("vector %0d status", i));
        end

        // R2: stored carry feeds add-with-carry
        apply(4'd0, 8'h01, 8'hFF, 1'b1, r);
        check({3'b0, status}, 8'h07, "R2", "carry preset");
        apply(4'd1, 8'h00, 8'h00, 1'b1, r);
        check(r, 8'h01, "R2", "addc with carry in");
        check({3'b0, status}, 8'h00, "R2", "addc flags");
        apply(4'd1, 8'h00, 8'h00, 1'b1, r);
        check(r, 8'h00, "R2", "addc without carry");
        apply(4'd1, 8'h0F, 8'hF0, 1'b1, r);
        check(r, 8'hFF, "R2", "addc result");
        check({3'b0, status}, 8'h10, "R2", "addc status");

        // R9: logic keeps C, DC, OV
        apply(4'd0, 8'h88, 8'h88, 1'b1, r);
        check({3'b0, status}, 8'h0B, "R9", "preset C DC OV");
        apply(4'd6, 8'hFF, 8'h80, 1'b1, r);
        check(r, 8'h80, "R9", "AND result");
        check({3'b0, status}, 8'h1B, "R9", "AND keeps C DC OV");
        apply(4'd3, 8'h00, 8'h00, 1'b1, r);
        check({3'b0, status}, 8'h0F, "R9", "move keeps C DC OV");

        // R10: no valid, and reserved code
        s0 = status;
        apply(4'd0, 8'h01, 8'h01, 1'b0, r);
        check(r, 8'h02, "R10", "result without valid");
        check({3'b0, status}, {3'b0, s0}, "R10", "status held without valid");
        apply(4'd15, 8'h55, 8'h3C, 1'b1, r);
        check(r, 8'h3C, "R10", "reserved code passes f");
        check({3'b0, status}, {3'b0, s0}, "R10", "reserved code keeps status");

        // R11: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({3'b0, status}, 8'h00, "R11", "status cleared by reset");
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule